// File: doc/BRIEF.md
# Scanline Timing and Display Status Unit

This block counts dot-clock cycles into display lines and lines into frames. It keeps live flags for the vertical blank, the horizontal blank and a line-compare match. It also raises single-cycle interrupt requests for three events: the start of vertical blank, the start of horizontal blank, and a compare match. Each request fires only when its enable bit is set. A processor reaches the unit through a byte-wide port with four locations. The status byte holds the three live flags and the three interrupt enables. The next byte holds the 8-bit line-compare value. The last two bytes are the low and high halves of the 16-bit line counter, which is read-only.

By default a line lasts 1232 cycles: 1024 cycles of active region followed by 208 cycles of horizontal blank. A frame has 228 lines, numbered 0 to 227. Lines 160 to 226 inclusive form the vertical blank. All of these figures are parameters, so a bench can shrink the frame.

Top module: `scan_timing`

## Requirements
- R1: The dot counter advances every cycle and restarts after `ACTIVE + BLANK` cycles. Each line therefore lasts exactly `ACTIVE + BLANK` cycles, 1232 by default.
- R2: The line counter advances by one at each line end and returns to 0 after line `LINES-1`, which is 227 by default.
- R3: Status bit 0 (vertical blank) reads 1 exactly while the line counter is between `VB_FIRST` and `VB_LAST` inclusive, 160 to 226 by default.
- R4: Status bit 1 (horizontal blank) rises in the first cycle after `ACTIVE` cycles of a line and falls in the first cycle of the next line.
- R5: Status bit 2 (line match) is re-evaluated in the first cycle of every line. It is 1 when the new line number equals the compare value, and it holds until the next line start.
- R6: `vblankIrq` pulses in the first cycle of line `VB_FIRST` when status bit 3 (vertical-blank enable) was set.
- R7: `hblankIrq` pulses in the same cycle that status bit 1 rises when status bit 4 (horizontal-blank enable) was set.
- R8: `vmatchIrq` pulses in the first cycle of a line whose number equals the compare value when status bit 5 (line-match enable) was set.
- R9: The port has four locations. A byte write to address 0 changes only bits 3 to 5; the values written to bits 0 to 2 and bits 6 to 7 have no effect. Address 0 reads {00, bit5, bit4, bit3, match, hblank, vblank}. Address 1 reads and writes the compare value.
- R10: Addresses 2 and 3 read the low and high bytes of the line counter. Writes to them have no effect.
- R11: Reset clears the dot and line counters, all flags, all enables, the compare value and every interrupt output.
- R12: Each interrupt output is high for exactly one cycle per event and never for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register byte select |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| vblankIrq | output | 1 | Vertical-blank interrupt request pulse |
| hblankIrq | output | 1 | Horizontal-blank interrupt request pulse |
| vmatchIrq | output | 1 | Line-match interrupt request pulse |

## Verification
The hardest cases to reach are the compare matches at the two ends of the frame. A match on line 0 can only happen through a wrap from the last line, because reset evaluates no match. A match on the last line must coincide with the vertical-blank flag having already fallen. The bench reaches both by moving the compare value to 0 and then to the last line number while the counters run, using a reduced frame of twelve lines with twelve cycles each. It also writes all-ones into the status byte and junk into the line-counter bytes mid-frame. A behavioural model predicts every read location and every interrupt output on every cycle.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;
  // Strobes from the counter control into the register datapath.
  typedef struct packed {
    logic        blankStart; // last active cycle: blank begins next cycle
    logic        lineWrap;   // last cycle of the line
    logic [15:0] nextLine;   // line number that follows the wrap
  } lineEvents_t;
endpackage

// File: rtl/scan_timing_ctrl.sv
module scan_timing_ctrl
  import scan_timing_pkg::*;
#(
  parameter int ACTIVE = 1024,
  parameter int BLANK  = 208,
  parameter int LINES  = 228
) (
  input  logic        clk,
  input  logic        rst,
  output lineEvents_t ev,
  output logic [15:0] lineNow
);
  localparam int LINE_LEN = ACTIVE + BLANK;
  localparam int DOT_W    = $clog2(LINE_LEN);
  localparam int LN_W     = $clog2(LINES);

  logic [DOT_W-1:0] dotCnt;
  logic [LN_W-1:0]  lineCnt;
  logic [LN_W-1:0]  lineNext;

  always_comb begin
    lineNext      = (lineCnt == LN_W'(LINES - 1)) ? '0 : lineCnt + 1'b1;
    ev.blankStart = (dotCnt == DOT_W'(ACTIVE - 1));
    ev.lineWrap   = (dotCnt == DOT_W'(LINE_LEN - 1));
    ev.nextLine   = 16'(lineNext);
    lineNow       = 16'(lineCnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dotCnt  <= '0;
      lineCnt <= '0;
    end else if (ev.lineWrap) begin
      dotCnt  <= '0;
      lineCnt <= lineNext;
    end else begin
      dotCnt  <= dotCnt + 1'b1;
    end
  end

  // R1: line length
  a_r1_dot_restart: assert property (@(posedge clk) disable iff (rst)
    ev.lineWrap |=> dotCnt == '0);
  a_r1_dot_step: assert property (@(posedge clk) disable iff (rst)
    !ev.lineWrap |=> dotCnt == $past(dotCnt) + 1'b1);
  // R2: line counter wrap and hold
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (ev.lineWrap && lineCnt == LN_W'(LINES - 1)) |=> lineCnt == '0);
  a_r2_line_hold: assert property (@(posedge clk) disable iff (rst)
    !ev.lineWrap |=> $stable(lineCnt));
endmodule

// File: rtl/scan_timing_regs.sv
module scan_timing_regs
  import scan_timing_pkg::*;
#(
  parameter int VB_FIRST = 160,
  parameter int VB_LAST  = 226
) (
  input  logic        clk,
  input  logic        rst,
  input  lineEvents_t ev,
  input  logic [15:0] lineNow,
  input  logic [1:0]  addr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic [2:0]  irqQ
);
  localparam int NUM_IRQ = 3;

  logic [NUM_IRQ-1:0] irqEn;   // [0] vblank, [1] hblank, [2] line match
  logic [NUM_IRQ-1:0] irqHit;
  logic [7:0]         cmpVal;
  logic               hbFlag;
  logic               vmFlag;
  logic               vbFlag;
  logic               unusedWrBits;

  assign unusedWrBits = ^{wrData[7:6], wrData[2:0]};
  assign vbFlag = (lineNow >= 16'(VB_FIRST)) && (lineNow <= 16'(VB_LAST));

  always_comb begin
    irqHit[0] = ev.lineWrap && (ev.nextLine == 16'(VB_FIRST));
    irqHit[1] = ev.blankStart;
    irqHit[2] = ev.lineWrap && (ev.nextLine == 16'(cmpVal));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqEn  <= '0;
      cmpVal <= '0;
    end else if (wrEn) begin
      if (addr == 2'd0) irqEn  <= wrData[5:3];
      if (addr == 2'd1) cmpVal <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hbFlag <= 1'b0;
      vmFlag <= 1'b0;
    end else begin
      if (ev.blankStart) hbFlag <= 1'b1;
      else if (ev.lineWrap) hbFlag <= 1'b0;
      if (ev.lineWrap) vmFlag <= (ev.nextLine == 16'(cmpVal));
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    always_ff @(posedge clk) begin
      if (rst) irqQ[i] <= 1'b0;
      else     irqQ[i] <= irqHit[i] & irqEn[i];
    end
    // R12: single-cycle pulses
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
      irqQ[i] |=> !irqQ[i]);
  end

  always_comb begin
    case (addr)
      2'd0:    rdData = {2'b00, irqEn, vmFlag, hbFlag, vbFlag};
      2'd1:    rdData = cmpVal;
      2'd2:    rdData = lineNow[7:0];
      default: rdData = lineNow[15:8];
    endcase
  end

  // R4: blank flag edges
  a_r4_hb_rise: assert property (@(posedge clk) disable iff (rst)
    ev.blankStart |=> hbFlag);
  a_r4_hb_fall: assert property (@(posedge clk) disable iff (rst)
    (ev.lineWrap && !ev.blankStart) |=> !hbFlag);
  // R5: match flag evaluated at line start
  a_r5_match_eval: assert property (@(posedge clk) disable iff (rst)
    ev.lineWrap |=> vmFlag == ($past(ev.nextLine) == 16'($past(cmpVal))));
  // R6: vblank request only on the first blank line
  a_r6_vb_line: assert property (@(posedge clk) disable iff (rst)
    irqQ[0] |-> lineNow == 16'(VB_FIRST));
  // R7: hblank request coincides with the flag rising
  a_r7_hb_with_flag: assert property (@(posedge clk) disable iff (rst)
    irqQ[1] |-> hbFlag);
endmodule

// File: rtl/scan_timing.sv
module scan_timing
  import scan_timing_pkg::*;
#(
  parameter int ACTIVE   = 1024,
  parameter int BLANK    = 208,
  parameter int LINES    = 228,
  parameter int VB_FIRST = 160,
  parameter int VB_LAST  = 226
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       vblankIrq,
  output logic       hblankIrq,
  output logic       vmatchIrq
);
  lineEvents_t ev;
  logic [15:0] lineNow;
  logic [2:0]  irqQ;

  scan_timing_ctrl #(.ACTIVE(ACTIVE), .BLANK(BLANK), .LINES(LINES)) ctrl_i (
    .clk(clk), .rst(rst), .ev(ev), .lineNow(lineNow)
  );

  scan_timing_regs #(.VB_FIRST(VB_FIRST), .VB_LAST(VB_LAST)) regs_i (
    .clk(clk), .rst(rst), .ev(ev), .lineNow(lineNow),
    .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqQ(irqQ)
  );

  assign vblankIrq = irqQ[0];
  assign hblankIrq = irqQ[1];
  assign vmatchIrq = irqQ[2];
endmodule

// File: tb/scan_timing_tb.sv
module scan_timing_tb_top;
  localparam int ACT = 8;
  localparam int BLK = 4;
  localparam int NL  = 12;
  localparam int VBF = 8;
  localparam int VBL = 10;
  localparam int LEN = ACT + BLK;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       vblankIrq, hblankIrq, vmatchIrq;

  int checks = 0;
  int fails = 0;
  bit checking = 0;
  bit done = 0;

  // behavioural reference state
  int mDot = 0, mLine = 0, mHb = 0, mVm = 0, mCmp = 0;
  int mEnVb = 0, mEnHb = 0, mEnVc = 0;
  int mIrqVb = 0, mIrqHb = 0, mIrqVc = 0;
  int prevIrq = 0;

  always #2.5 clk = ~clk;

  scan_timing #(.ACTIVE(ACT), .BLANK(BLK), .LINES(NL), .VB_FIRST(VBF), .VB_LAST(VBL)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .vblankIrq(vblankIrq), .hblankIrq(hblankIrq), .vmatchIrq(vmatchIrq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mDot = 0; mLine = 0; mHb = 0; mVm = 0; mCmp = 0;
      mEnVb = 0; mEnHb = 0; mEnVc = 0;
      mIrqVb = 0; mIrqHb = 0; mIrqVc = 0;
    end else begin
      mIrqVb = 0; mIrqHb = 0; mIrqVc = 0;
      if (mDot == ACT - 1) begin
        mHb = 1;
        mIrqHb = mEnHb;
      end
      if (mDot == LEN - 1) begin
        mDot = 0;
        mHb = 0;
        mLine = (mLine + 1) % NL;
        mVm = (mLine == mCmp);
        mIrqVb = mEnVb && (mLine == VBF);
        mIrqVc = mEnVc && mVm;
      end else begin
        mDot++;
      end
      if (wrEn && addr == 2'd0) begin
        mEnVb = wrData[3]; mEnHb = wrData[4]; mEnVc = wrData[5];
      end
      if (wrEn && addr == 2'd1) mCmp = wrData;
    end
  end

  function automatic int expRd(input int a);
    int vb;
    vb = (mLine >= VBF && mLine <= VBL);
    case (a)
      0: return (mEnVc << 5) | (mEnHb << 4) | (mEnVb << 3) | (mVm << 2) | (mHb << 1) | vb;
      1: return mCmp;
      2: return mLine & 255;
      default: return mLine >> 8;
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (checking) begin
      int vb;
      int irqNow;
      vb = (mLine >= VBF && mLine <= VBL);
      irqNow = {vblankIrq, hblankIrq, vmatchIrq};
      if (addr == 2'd0) begin
        chk("R3 vblank flag", rdData[0], vb);
        chk("R1 R4 hblank flag", rdData[1], mHb);
        chk("R5 match flag", rdData[2], mVm);
        chk("R9 status byte", rdData, expRd(0));
      end else if (addr == 2'd1) begin
        chk("R9 compare byte", rdData, expRd(1));
      end else begin
        chk("R2 R10 line counter byte", rdData, expRd(addr));
      end
      chk("R6 vblank irq", vblankIrq, mIrqVb);
      chk("R7 hblank irq", hblankIrq, mIrqHb);
      chk("R8 vmatch irq", vmatchIrq, mIrqVc);
      chk("R12 no back-to-back pulse", irqNow & prevIrq, 0);
      prevIrq = irqNow;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      addr = addr + 2'd1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic resetCheck();
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      addr = 2'(a);
      #1;
      chk("R11 reset clears register", rdData, 0);
      chk("R11 reset clears irqs", {vblankIrq, hblankIrq, vmatchIrq}, 0);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (2) @(posedge clk);
    resetCheck();
    @(negedge clk);
    rst = 1'b0;
    checking = 1;
    idle(20);
    wr(2'd0, 8'hFF);          // all enables; other bits ignored
    wr(2'd1, 8'd5);
    idle(2 * NL * LEN);
    wr(2'd2, 8'hAA);          // ignored
    wr(2'd3, 8'h55);          // ignored
    idle(50);
    wr(2'd1, 8'd0);           // match on line 0 after wrap
    idle(NL * LEN + 20);
    wr(2'd1, NL - 1);         // match on the last line
    idle(NL * LEN + 20);
    wr(2'd1, 8'd200);         // never matches
    wr(2'd0, 8'h10);          // hblank enable only
    idle(NL * LEN);
    wr(2'd0, 8'h07);          // live-flag bits written: no effect
    idle(60);
    checking = 0;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    resetCheck();
    @(negedge clk);
    rst = 1'b0;
    prevIrq = 0;
    checking = 1;
    wr(2'd0, 8'h28);
    idle(NL * LEN);
    checking = 0;
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end
endmodule